// File: doc/BRIEF.md
# Serial Receive Buffer with Programmable Trigger

This block is the receive-side byte queue of a memory-mapped serial controller. A deserializer pushes complete bytes into a 16-entry circular store. Software drains the store one byte per read of the receive data register and can read the current occupancy at any time. The output `pop_data` always shows the byte that the next read returns.

A 2-bit trigger code, taken from the FIFO control register, selects how full the queue must be before the data-ready flag is raised. The four codes map to 1, 4, 8 and 14 bytes, so the spacing is not linear. When a push brings the occupancy up to the selected level, the flag is set. If the receive interrupt is enabled at that moment, the interrupt is raised as well. A write to the serial control register with the interrupt-enable bit clear drops the interrupt. A flush bit in the FIFO control register empties the queue.

The block captures the control bits on the register write strobes `fcr_wr` and `ctl_wr`. A new value takes effect from the next cycle.

Top module: `rx_trigger_fifo`

## Requirements
- R1: After reset the occupancy is 0, `data_full` and `rx_irq` are 0, the trigger level is 1 and reception is disabled.
- R2: Bytes come out in the order they were accepted. Up to 16 are held, and the read and write positions wrap after entry 15.
- R3: A byte offered while 16 are already held is discarded, and the occupancy stays 16.
- R4: The trigger code `fcr_trig` selects the level: code 0 gives 1 byte, code 1 gives 4, code 2 gives 8 and code 3 gives 14.
- R5: An accepted byte that leaves the occupancy at or above the level sets `data_full` in the next cycle.
- R6: A read that leaves the occupancy below the level clears `data_full`.
- R7: With the queue empty, `pop_data` is 8'hFF and a read changes neither the occupancy nor the read position.
- R8: `fcr_wr` with `fcr_flush` = 1 zeroes the occupancy and both positions and clears `data_full`. A byte offered in the same cycle is dropped.
- R9: Bytes are accepted only while the stored receive-enable bit (`ctl_rx_en`, captured on `ctl_wr`) is 1.
- R10: `rx_irq` rises only when an accepted byte reaches the level while the stored interrupt-enable bit (`ctl_rx_ie`) is 1. A read does not clear it.
- R11: `ctl_wr` with `ctl_rx_ie` = 0 deasserts `rx_irq` in the next cycle.
- R12: A push and a read in the same cycle leave the occupancy unchanged, and `data_full` is decided from that resulting occupancy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_valid | input | 1 | Deserializer offers a byte this cycle |
| push_data | input | 8 | Offered byte |
| pop | input | 1 | Read of the receive data register |
| pop_data | output | 8 | Oldest held byte, or 8'hFF when empty |
| fcr_wr | input | 1 | FIFO control register write strobe |
| fcr_trig | input | 2 | Trigger code (control bits 7:6) |
| fcr_flush | input | 1 | Flush bit (control bit 1) |
| ctl_wr | input | 1 | Serial control register write strobe |
| ctl_rx_en | input | 1 | Receive enable (control bit 4) |
| ctl_rx_ie | input | 1 | Receive interrupt enable (control bit 6) |
| count | output | 5 | Occupancy, 0 to 16 |
| data_full | output | 1 | Occupancy reached the trigger level |
| rx_irq | output | 1 | Receive interrupt |

## Verification
A position or occupancy that has gone wrong shows up at `pop_data` as soon as that entry becomes the oldest. It can therefore stay hidden until the queue drains past it, so the bench drains the queue fully after wrapping and after overflow. An occupancy that is off by one moves `count` at once. It also moves `data_full` by one byte against the level, which the bench checks just below and just at each of the four levels. An interrupt-enable bit that was captured wrongly shows on `rx_irq` one cycle after the byte that reaches the level.

// File: rtl/rx_trigger_fifo.sv
`timescale 1ns/1ps
module rx_trigger_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int LVL0   = 1,
  parameter int LVL1   = 4,
  parameter int LVL2   = 8,
  parameter int LVL3   = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] pop_data,
  input  logic              fcr_wr,
  input  logic [1:0]        fcr_trig,
  input  logic              fcr_flush,
  input  logic              ctl_wr,
  input  logic              ctl_rx_en,
  input  logic              ctl_rx_ie,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic              data_full,
  output logic              rx_irq
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  head_q, tail_q;
  logic [CNT_W-1:0]  cnt_q, thr, cnt_nx;
  logic [1:0]        trig_q;
  logic              rx_en_q, rie_q, full_q, irq_q;

  wire flush = fcr_wr & fcr_flush;
  wire take  = push_valid & rx_en_q & (cnt_q < CNT_W'(DEPTH));
  wire give  = pop & (cnt_q != '0);
  wire reach = cnt_nx >= thr;
  wire [PTR_W-1:0] head_nx = (head_q == PTR_W'(DEPTH-1)) ? '0 : head_q + 1'b1;
  wire [PTR_W-1:0] tail_nx = (tail_q == PTR_W'(DEPTH-1)) ? '0 : tail_q + 1'b1;

  assign cnt_nx = cnt_q + CNT_W'(take) - CNT_W'(give);

  always_comb begin
    case (trig_q)
      2'd0:    thr = CNT_W'(LVL0);
      2'd1:    thr = CNT_W'(LVL1);
      2'd2:    thr = CNT_W'(LVL2);
      default: thr = CNT_W'(LVL3);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      cnt_q   <= '0;
      trig_q  <= 2'd0;
      rx_en_q <= 1'b0;
      rie_q   <= 1'b0;
      full_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (fcr_wr) trig_q <= fcr_trig;
      if (ctl_wr) begin
        rx_en_q <= ctl_rx_en;
        rie_q   <= ctl_rx_ie;
      end
      if (flush) begin
        head_q <= '0;
        tail_q <= '0;
        cnt_q  <= '0;
        full_q <= 1'b0;
      end else begin
        if (take) head_q <= head_nx;
        if (give) tail_q <= tail_nx;
        cnt_q <= cnt_nx;
        if (take && reach)       full_q <= 1'b1;
        else if (give && !reach) full_q <= 1'b0;
      end
      if (ctl_wr && !ctl_rx_ie)                   irq_q <= 1'b0;
      else if (!flush && take && reach && rie_q) irq_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (take && !flush) mem[head_q] <= push_data;
  end

  assign pop_data  = (cnt_q != '0) ? mem[tail_q] : '1;
  assign count     = cnt_q;
  assign data_full = full_q;
  assign rx_irq    = irq_q;
endmodule

// File: rtl/rx_trigger_fifo_chk.sv
`timescale 1ns/1ps
module rx_trigger_fifo_chk #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              push_valid,
  input logic              pop,
  input logic              fcr_wr,
  input logic              fcr_flush,
  input logic              ctl_wr,
  input logic              ctl_rx_ie,
  input logic [CNT_W-1:0]  count,
  input logic [DATA_W-1:0] pop_data,
  input logic              data_full,
  input logic              rx_irq,
  input logic              rx_en_q,
  input logic              rie_q
);
  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_W'(DEPTH) && !pop && !(fcr_wr && fcr_flush)) |=> count == CNT_W'(DEPTH));
  assert_empty_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |-> pop_data == '1);
  assert_empty_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && !push_valid) |=> count == '0);
  assert_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fcr_wr && fcr_flush) |=> (count == '0 && !data_full));
  assert_rx_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en_q && !pop && !fcr_wr) |=> $stable(count));
  assert_irq_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_irq) |-> ($past(rie_q) && data_full));
  assert_irq_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !ctl_rx_ie) |=> !rx_irq);
endmodule

bind rx_trigger_fifo rx_trigger_fifo_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .pop(pop),
  .fcr_wr(fcr_wr), .fcr_flush(fcr_flush), .ctl_wr(ctl_wr), .ctl_rx_ie(ctl_rx_ie),
  .count(count), .pop_data(pop_data), .data_full(data_full), .rx_irq(rx_irq),
  .rx_en_q(rx_en_q), .rie_q(rie_q)
);

// File: tb/rx_trigger_fifo_bench.sv
`timescale 1ns/1ps
module rx_trigger_fifo_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic push_valid = 0, pop = 0, fcr_wr = 0, fcr_flush = 0, ctl_wr = 0, ctl_rx_en = 0, ctl_rx_ie = 0;
  logic [7:0] push_data = 0;
  logic [1:0] fcr_trig = 0;
  logic [7:0] pop_data;
  logic [4:0] count;
  logic data_full, rx_irq;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  rx_trigger_fifo u_rx_trigger_fifo (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
    .pop(pop), .pop_data(pop_data), .fcr_wr(fcr_wr), .fcr_trig(fcr_trig),
    .fcr_flush(fcr_flush), .ctl_wr(ctl_wr), .ctl_rx_en(ctl_rx_en), .ctl_rx_ie(ctl_rx_ie),
    .count(count), .data_full(data_full), .rx_irq(rx_irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push_byte(input logic [7:0] d);
    @(negedge clk); push_valid = 1; push_data = d;
    @(negedge clk); push_valid = 0;
  endtask

  task automatic pop_byte(output logic [7:0] d);
    @(negedge clk); pop = 1; #0.1 d = pop_data;
    @(negedge clk); pop = 0;
  endtask

  task automatic push_pop(input logic [7:0] din, output logic [7:0] dout);
    @(negedge clk); push_valid = 1; push_data = din; pop = 1; #0.1 dout = pop_data;
    @(negedge clk); push_valid = 0; pop = 0;
  endtask

  task automatic write_fcr(input logic [1:0] trig, input logic flush);
    @(negedge clk); fcr_wr = 1; fcr_trig = trig; fcr_flush = flush;
    @(negedge clk); fcr_wr = 0; fcr_flush = 0;
  endtask

  task automatic write_ctl(input logic en, input logic ie);
    @(negedge clk); ctl_wr = 1; ctl_rx_en = en; ctl_rx_ie = ie;
    @(negedge clk); ctl_wr = 0;
  endtask

  task automatic t_reset;
    chk("R1 count", count, 0);
    chk("R1 data_full", data_full, 0);
    chk("R1 rx_irq", rx_irq, 0);
    chk("R7 empty pop_data", pop_data, 8'hFF);
  endtask

  task automatic t_enable_gate;
    push_byte(8'h11);
    chk("R9 disabled push ignored", count, 0);
    write_ctl(1, 0);
    push_byte(8'h22);
    chk("R9 enabled push count", count, 1);
    chk("R1 default level 1 sets flag", data_full, 1);
    write_fcr(0, 1);
  endtask

  task automatic t_empty_pop;
    logic [7:0] d;
    pop_byte(d);
    chk("R7 empty read value", d, 8'hFF);
    chk("R7 empty read count", count, 0);
    push_byte(8'h3C);
    pop_byte(d);
    chk("R7 position unchanged after empty read", d, 8'h3C);
    chk("R6 flag clears below level", data_full, 0);
  endtask

  task automatic t_order_wrap_overflow;
    logic [7:0] d;
    int bad = 0;
    for (int i = 0; i < 10; i++) push_byte(8'h40 + 8'(i));
    for (int i = 0; i < 10; i++) begin
      pop_byte(d);
      if (d != 8'h40 + 8'(i)) bad++;
    end
    chk("R2 order first pass mismatches", bad, 0);
    for (int i = 0; i < 16; i++) push_byte(8'h80 + 8'(i));
    chk("R2 full count after wrap", count, 16);
    push_byte(8'hEE);
    chk("R3 overflow count", count, 16);
    bad = 0;
    for (int i = 0; i < 16; i++) begin
      pop_byte(d);
      if (d != 8'h80 + 8'(i)) bad++;
    end
    chk("R2 R3 order after wrap and overflow mismatches", bad, 0);
    chk("R3 drained count", count, 0);
    chk("R3 discarded byte absent", pop_data, 8'hFF);
  endtask

  task automatic t_levels;
    logic [7:0] d;
    int lvl [4] = '{1, 4, 8, 14};
    for (int c = 0; c < 4; c++) begin
      write_fcr(2'(c), 1);
      for (int i = 0; i < lvl[c] - 1; i++) push_byte(8'(i));
      chk($sformatf("R4 R5 code %0d below level", c), data_full, 0);
      push_byte(8'h99);
      chk($sformatf("R4 R5 code %0d at level", c), data_full, 1);
      pop_byte(d);
      chk($sformatf("R6 code %0d after read", c), data_full, 0);
    end
    write_fcr(0, 1);
  endtask

  task automatic t_flush;
    logic [7:0] d;
    for (int i = 0; i < 5; i++) push_byte(8'h10 + 8'(i));
    write_fcr(1, 1);
    chk("R8 flush count", count, 0);
    chk("R8 flush flag", data_full, 0);
    chk("R8 flush empty value", pop_data, 8'hFF);
    @(negedge clk); fcr_wr = 1; fcr_flush = 1; fcr_trig = 1; push_valid = 1; push_data = 8'h77;
    @(negedge clk); fcr_wr = 0; fcr_flush = 0; push_valid = 0;
    chk("R8 byte with flush dropped", count, 0);
    push_byte(8'h5A);
    pop_byte(d);
    chk("R8 data after flush", d, 8'h5A);
  endtask

  task automatic t_irq;
    write_fcr(1, 1);
    for (int i = 0; i < 4; i++) push_byte(8'(i));
    chk("R10 flag without enable", data_full, 1);
    chk("R10 no irq without enable", rx_irq, 0);
    write_fcr(1, 1);
    write_ctl(1, 1);
    for (int i = 0; i < 3; i++) push_byte(8'(i));
    chk("R10 irq below level", rx_irq, 0);
    push_byte(8'h03);
    chk("R10 irq at level", rx_irq, 1);
    begin
      logic [7:0] d;
      pop_byte(d);
    end
    chk("R10 irq held after read", rx_irq, 1);
    write_ctl(1, 0);
    chk("R11 irq dropped", rx_irq, 0);
    write_fcr(0, 1);
  endtask

  task automatic t_simultaneous;
    logic [7:0] d;
    write_fcr(1, 1);
    for (int i = 0; i < 4; i++) push_byte(8'hA0 + 8'(i));
    push_pop(8'hA4, d);
    chk("R12 count kept at level", count, 4);
    chk("R12 flag kept at level", data_full, 1);
    chk("R12 oldest returned", d, 8'hA0);
    pop_byte(d);
    chk("R6 flag after drop to 3", data_full, 0);
    push_pop(8'hA5, d);
    chk("R12 count kept below level", count, 3);
    chk("R12 flag stays clear below level", data_full, 0);
    chk("R12 order under simultaneous", d, 8'hA2);
    write_fcr(0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    fork
      begin
        t_reset();
        t_enable_gate();
        t_empty_pop();
        t_order_wrap_overflow();
        t_levels();
        t_flush();
        t_irq();
        t_simultaneous();
      end
      begin
        #500us;
        failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule